// File: doc/BRIEF.md
# Packet Header Framer with Sequencing

The block turns a payload stream into 64-bit packets that each begin with a header. Payload elements arrive 32 or 64 bits wide, as a parameter sets. Each packet carries a 128-bit sideband that holds a header template in its upper half and a timestamp in its lower half. The packet ends on the beat that has `in_last` set. The block keeps every packet in a payload buffer until its last element is in, which lets it know the byte count. It then sends the header word, then the timestamp word if the template's has-time bit is set, then the packed payload.

The header word that goes out differs from the template in two fields. The length field holds the real payload bytes plus the header bytes, plus the timestamp bytes when present. The sequence field holds a 12-bit count that the block keeps itself, or the template's own value when `SEQ_INTERNAL` is 0. A small header queue sits next to the payload buffer, so a new packet can come in while earlier ones are still going out.

Both streams use valid/ready. A beat transfers on a clock edge where valid and ready are both high. `in_ready` does not depend on `in_valid`. Once the block raises `out_valid`, it holds the word until `out_ready` takes it. A packet larger than the payload buffer can never complete, so the buffer must be sized for the largest packet. Reset is synchronous and active high.

Top module: `pkt_framer`

## Requirements
- R1: Each packet is sent in this order: one header word, then one timestamp word (sideband bits 63:0) only if template bit 125 is 1, then the payload words. `out_last` is 1 only on the final payload word.
- R2: The header length field (output bits 47:32, template bits 111:96) equals the real payload bytes plus 8, plus another 8 when bit 125 is set. Padding bytes are not counted. The template's own length value is discarded.
- R3: With 32-bit elements, two elements fill one output word: the earlier element goes in bits 63:32 and the later in bits 31:0. A packet with an odd element count ends with a word whose bits 31:0 are zero. With 64-bit elements, each element is one word.
- R4: With `SEQ_INTERNAL`=1, the sequence field (output bits 59:48) is 0 for the first packet after reset and rises by one for each packet sent, wrapping from 4095 to 0. With `SEQ_INTERNAL`=0, it carries template bits 123:112 unchanged.
- R5: A one-cycle `seq_clear` pulse sets the internal sequence count to zero, so the next header sent carries sequence 0.
- R6: Type (bits 127:126), has-time, end-of-burst (bit 124), source ID (bits 95:80), destination ID (bits 79:64) and timestamp are taken from the sideband on the first beat of the packet. The sideband on later beats is ignored.
- R7: No word of a packet leaves the block until its last input element has been accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R9: `in_ready` falls when either the payload buffer or the header queue is full, and no accepted data is lost. Input is still accepted while an earlier packet is being sent.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seq_clear | input | 1 | Sets the internal sequence count to zero |
| in_data | input | ELEM_W | Payload element |
| in_side | input | 128 | Header template (127:64) and timestamp (63:0) |
| in_last | input | 1 | Final element of the packet |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can accept an element |
| out_data | output | 64 | Output word |
| out_last | output | 1 | Final word of the packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
The bench drives two copies of the block from the same input stream. One has 32-bit elements and an internal sequence count. The other has 64-bit elements and passes the template's sequence number through. A behavioural model predicts every output word, and each word is compared as it is handed over.

Each kind of internal fault shows up at the ports. A wrong byte count or packing state shows in the header or payload word of the packet it affects. A lost phase shows as a missing or duplicated timestamp word in that same packet. A header popped at the wrong time shows in the very next packet. An off-by-one in the sequence count shows on the next header. A wrap fault only appears after 4096 packets, so the bench sends a run that long. Store-and-forward is checked by counting completed input packets against headers already sent.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int HDR_W   = 128;
  localparam int WORD_W  = 64;
  localparam int HT_BIT  = 125;
  localparam int SEQ_LSB = 112;
  localparam int LEN_LSB = 96;

  typedef enum logic [1:0] {PH_HDR, PH_TS, PH_PAY} phase_e;

  // total bytes on the wire: payload plus header word plus optional timestamp
  function automatic logic [15:0] wire_len(input logic [15:0] payload_bytes, input logic has_time);
    return payload_bytes + 16'd8 + (has_time ? 16'd8 : 16'd0);
  endfunction
endpackage

// File: rtl/framer_fifo.sv
module framer_fifo #(
  parameter int W    = 65,
  parameter int LOG2 = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int DEPTH = 2 ** LOG2;
  localparam logic [LOG2:0] DEPTH_C = (LOG2 + 1)'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [LOG2-1:0] wr_ptr, rd_ptr;
  logic [LOG2:0]   count;

  assign full     = (count == DEPTH_C);
  assign empty    = (count == '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + {{LOG2{1'b0}}, push} - {{LOG2{1'b0}}, pop};
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/framer_packer.sv
module framer_packer
  import framer_pkg::*;
#(
  parameter int ELEM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ELEM_W-1:0] in_data,
  input  logic [HDR_W-1:0]  in_side,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              pay_full,
  input  logic              hdr_full,
  output logic              wr_push,
  output logic [WORD_W-1:0] wr_word,
  output logic              wr_last,
  output logic              hdr_push,
  output logic [HDR_W-1:0]  hdr_word
);
  localparam logic [15:0] BYTES_PER = 16'(ELEM_W / 8);

  logic             acc;
  logic             first_q;
  logic [HDR_W-1:0] side_q, side_now;
  logic [15:0]      bytes_q, bytes_next;

  assign in_ready   = !pay_full && !hdr_full;
  assign acc        = in_valid && in_ready;
  assign side_now   = first_q ? in_side : side_q;
  assign bytes_next = (first_q ? 16'd0 : bytes_q) + BYTES_PER;
  assign hdr_push   = acc && in_last;
  assign hdr_word   = {side_now[HDR_W-1:LEN_LSB+16],
                       wire_len(bytes_next, side_now[HT_BIT]),
                       side_now[LEN_LSB-1:0]};
  assign wr_last    = in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      side_q  <= '0;
      bytes_q <= '0;
    end else if (acc) begin
      first_q <= in_last;
      bytes_q <= bytes_next;
      if (first_q) side_q <= in_side;
    end
  end

  generate
    if (ELEM_W == 32) begin : g_pair
      logic        half_q;
      logic [31:0] hold_q;
      assign wr_push = acc && (half_q || in_last);
      assign wr_word = half_q ? {hold_q, in_data} : {in_data, 32'h0};
      always_ff @(posedge clk) begin
        if (rst) begin
          half_q <= 1'b0;
          hold_q <= '0;
        end else if (acc) begin
          half_q <= !half_q && !in_last;
          if (!half_q) hold_q <= in_data;
        end
      end
    end else begin : g_word
      assign wr_push = acc;
      assign wr_word = in_data;
    end
  endgenerate

  // a header is queued only together with the final payload word of its packet
  assert_hdr_with_tail_R7: assert property (@(posedge clk) disable iff (rst)
    hdr_push |-> (wr_push && wr_last));
endmodule

// File: rtl/framer_emitter.sv
module framer_emitter
  import framer_pkg::*;
#(
  parameter bit SEQ_INTERNAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_clear,
  input  logic [HDR_W-1:0]  hdr_word,
  input  logic              hdr_empty,
  output logic              hdr_pop,
  input  logic [WORD_W-1:0] pay_word,
  input  logic              pay_last,
  input  logic              pay_empty,
  output logic              pay_pop,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  phase_e      phase_q;
  logic [11:0] seq_q, seq_field;
  logic        fire;

  assign seq_field = SEQ_INTERNAL ? seq_q : hdr_word[SEQ_LSB+11:SEQ_LSB];
  assign fire      = out_valid && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    pay_pop   = 1'b0;
    hdr_pop   = 1'b0;
    case (phase_q)
      PH_HDR: begin
        out_valid = !hdr_empty;
        out_data  = {hdr_word[HDR_W-1:SEQ_LSB+12], seq_field, hdr_word[SEQ_LSB-1:WORD_W]};
      end
      PH_TS: begin
        out_valid = 1'b1;
        out_data  = hdr_word[WORD_W-1:0];
      end
      default: begin
        out_valid = !pay_empty;
        out_data  = pay_word;
        out_last  = pay_last;
        pay_pop   = fire;
        hdr_pop   = fire && pay_last;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_HDR;
    end else if (fire) begin
      case (phase_q)
        PH_HDR:  phase_q <= hdr_word[HT_BIT] ? PH_TS : PH_PAY;
        PH_TS:   phase_q <= PH_PAY;
        default: if (pay_last) phase_q <= PH_HDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || seq_clear) seq_q <= '0;
    else if (fire && phase_q == PH_HDR) seq_q <= seq_q + 12'd1;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  assert_hdr_held_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_HDR) |-> !hdr_empty);
  assert_last_restarts_R1: assert property (@(posedge clk) disable iff (rst)
    (fire && out_last) |=> (phase_q == PH_HDR));

  generate
    if (SEQ_INTERNAL) begin : g_seq_chk
      assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        seq_clear |=> (!(out_valid && phase_q == PH_HDR) || out_data[59:48] == 12'd0));
    end
  endgenerate
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import framer_pkg::*;
#(
  parameter int ELEM_W       = 32,
  parameter int BUF_LOG2     = 5,
  parameter int HDR_LOG2     = 2,
  parameter bit SEQ_INTERNAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_clear,
  input  logic [ELEM_W-1:0] in_data,
  input  logic [127:0]      in_side,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [63:0]       out_data,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int PAY_W = WORD_W + 1;

  logic              wr_push, wr_last, pay_full, pay_empty, pay_pop;
  logic [WORD_W-1:0] wr_word;
  logic [PAY_W-1:0]  pay_q;
  logic              hdr_push, hdr_full, hdr_empty, hdr_pop;
  logic [HDR_W-1:0]  hdr_in, hdr_q;

  framer_packer #(.ELEM_W(ELEM_W)) u_pack (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_side(in_side), .in_last(in_last),
    .in_valid(in_valid), .in_ready(in_ready),
    .pay_full(pay_full), .hdr_full(hdr_full),
    .wr_push(wr_push), .wr_word(wr_word), .wr_last(wr_last),
    .hdr_push(hdr_push), .hdr_word(hdr_in)
  );

  framer_fifo #(.W(PAY_W), .LOG2(BUF_LOG2)) u_pay (
    .clk(clk), .rst(rst),
    .push(wr_push), .push_data({wr_last, wr_word}), .full(pay_full),
    .pop(pay_pop), .pop_data(pay_q), .empty(pay_empty)
  );

  framer_fifo #(.W(HDR_W), .LOG2(HDR_LOG2)) u_hdr (
    .clk(clk), .rst(rst),
    .push(hdr_push), .push_data(hdr_in), .full(hdr_full),
    .pop(hdr_pop), .pop_data(hdr_q), .empty(hdr_empty)
  );

  framer_emitter #(.SEQ_INTERNAL(SEQ_INTERNAL)) u_emit (
    .clk(clk), .rst(rst), .seq_clear(seq_clear),
    .hdr_word(hdr_q), .hdr_empty(hdr_empty), .hdr_pop(hdr_pop),
    .pay_word(pay_q[WORD_W-1:0]), .pay_last(pay_q[WORD_W]),
    .pay_empty(pay_empty), .pay_pop(pay_pop),
    .out_data(out_data), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  // a payload word is never offered without its header already queued
  assert_store_forward_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pay_empty && pay_pop) |-> !hdr_empty);
endmodule

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
  typedef struct packed {
    logic [63:0] d;
    logic        l;
    logic [1:0]  k;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst = 1'b1, seq_clear = 1'b0;
  logic         drv_valid = 1'b0, drv_last = 1'b0, ordy = 1'b1;
  logic [31:0]  drv_e = '0;
  logic [127:0] drv_side = '0;
  logic         n_rdy, w_rdy, n_v, w_v, n_l, w_l;
  logic [63:0]  n_d, w_d;

  exp_t qn[$];
  exp_t qw[$];
  int checks = 0, errors = 0, rdy_mode = 0, cyc = 0, pkts_done = 0;
  int started[2];
  bit stall_q[2];
  logic [63:0] hold_d[2];
  logic hold_l[2];
  logic [31:0] pkt_idx = 0;
  logic [11:0] seq_m = 0;

  pkt_framer #(.ELEM_W(32), .SEQ_INTERNAL(1'b1)) dut (
    .clk(clk), .rst(rst), .seq_clear(seq_clear),
    .in_data(drv_e), .in_side(drv_side), .in_last(drv_last),
    .in_valid(drv_valid && w_rdy), .in_ready(n_rdy),
    .out_data(n_d), .out_last(n_l), .out_valid(n_v), .out_ready(ordy));

  pkt_framer #(.ELEM_W(64), .SEQ_INTERNAL(1'b0)) dut_wide (
    .clk(clk), .rst(rst), .seq_clear(seq_clear),
    .in_data({drv_e, drv_e ^ 32'hA5A5A5A5}), .in_side(drv_side), .in_last(drv_last),
    .in_valid(drv_valid && n_rdy), .in_ready(w_rdy),
    .out_data(w_d), .out_last(w_l), .out_valid(w_v), .out_ready(ordy));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    cyc++;
    ordy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  function automatic string tag_of(input logic [1:0] k, input bit wide);
    if (k == 2'd0) return "R2/R4/R5/R6 header";
    if (k == 2'd1) return "R1/R6 timestamp";
    return wide ? "R1 payload" : "R3 payload";
  endfunction

  task automatic watch(input int w, input logic v, input logic r, input logic [63:0] d, input logic l);
    exp_t e;
    if (stall_q[w]) check(v === 1'b1 && d === hold_d[w] && l === hold_l[w], "R8 held word", d, hold_d[w]);
    stall_q[w] = v && !r;
    hold_d[w] = d;
    hold_l[w] = l;
    if (v && r) begin
      if ((w == 1 ? qw.size() : qn.size()) == 0) begin
        check(1'b0, "R7 word with nothing expected", d, 64'h0);
      end else begin
        e = (w == 1) ? qw.pop_front() : qn.pop_front();
        if (e.k == 2'd0) begin
          check(pkts_done > started[w], "R7 header before last input", 64'(started[w]), 64'(pkts_done));
          started[w]++;
        end
        check(d === e.d, tag_of(e.k, w == 1), d, e.d);
        check(l === e.l, "R1 last flag", 64'(l), 64'(e.l));
      end
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    if (rst) begin
      stall_q[0] = 1'b0;
      stall_q[1] = 1'b0;
    end else begin
      watch(0, n_v, ordy, n_d, n_l);
      watch(1, w_v, ordy, w_d, w_l);
    end
  end

  function automatic logic [31:0] elem(input logic [31:0] idx, input int i);
    return {idx[15:0], 16'(i)};
  endfunction

  task automatic put(input logic [31:0] e, input logic last, input logic [127:0] side);
    @(negedge clk);
    drv_valid = 1'b1;
    drv_e = e;
    drv_last = last;
    drv_side = side;
    #5;
    while (!(n_rdy && w_rdy)) begin
      @(negedge clk);
      #5;
    end
    @(posedge clk);
  endtask

  task automatic send_pkt(input int n, input bit ht);
    logic [31:0]  idx;
    logic [127:0] side;
    logic [15:0]  ln_n, ln_w;
    exp_t e;
    idx = pkt_idx;
    pkt_idx++;
    side = {idx[1:0], ht, idx[2], 12'(idx * 37), 16'hDEAD,
            16'(32'h1000 + idx), 16'(32'h2000 + idx), 64'hCAFE000000000000 + 64'(idx * 77)};
    ln_n = 16'(n * 4 + 8 + (ht ? 8 : 0));
    ln_w = 16'(n * 8 + 8 + (ht ? 8 : 0));
    e = '{d: {side[127:124], seq_m, ln_n, side[95:64]}, l: 1'b0, k: 2'd0};
    qn.push_back(e);
    e = '{d: {side[127:112], ln_w, side[95:64]}, l: 1'b0, k: 2'd0};
    qw.push_back(e);
    seq_m = seq_m + 12'd1;
    if (ht) begin
      e = '{d: side[63:0], l: 1'b0, k: 2'd1};
      qn.push_back(e);
      qw.push_back(e);
    end
    for (int i = 0; i < n; i += 2) begin
      e = '{d: {elem(idx, i), (i + 1 < n) ? elem(idx, i + 1) : 32'h0}, l: (i + 2 >= n), k: 2'd2};
      qn.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      e = '{d: {elem(idx, i), elem(idx, i) ^ 32'hA5A5A5A5}, l: (i == n - 1), k: 2'd2};
      qw.push_back(e);
    end
    for (int i = 0; i < n; i++) put(elem(idx, i), i == n - 1, (i == 0) ? side : ~side);
    pkts_done++;
    @(negedge clk);
    drv_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((qn.size() != 0 || qw.size() != 0) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(qn.size() == 0 && qw.size() == 0, "R1 all expected words sent", 64'(qn.size() + qw.size()), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #5;
    check(n_v === 1'b0 && w_v === 1'b0, "R10 out_valid after reset", {62'h0, n_v, w_v}, 64'h0);
    check(n_rdy === 1'b1 && w_rdy === 1'b1, "R10 in_ready after reset", {62'h0, n_rdy, w_rdy}, 64'h3);

    // mixed lengths, timestamp on and off, odd counts for padding
    send_pkt(1, 1'b0);
    send_pkt(2, 1'b1);
    send_pkt(3, 1'b0);
    send_pkt(5, 1'b1);
    send_pkt(8, 1'b0);
    wait_idle();

    // irregular output back-pressure
    rdy_mode = 1;
    for (int p = 0; p < 6; p++) send_pkt(p + 2, p[0]);
    wait_idle();

    // output fully stalled: header queue fills and input stops
    rdy_mode = 2;
    for (int p = 0; p < 4; p++) send_pkt(2, 1'b1);
    @(negedge clk);
    #5;
    check(n_rdy === 1'b0 && w_rdy === 1'b0, "R9 in_ready low when queue full", {62'h0, n_rdy, w_rdy}, 64'h0);
    check(n_v === 1'b1 && w_v === 1'b1, "R7 stored packet offered", {62'h0, n_v, w_v}, 64'h3);
    rdy_mode = 0;
    send_pkt(4, 1'b0);
    wait_idle();

    // sequence clear while idle
    @(negedge clk);
    seq_clear = 1'b1;
    @(negedge clk);
    seq_clear = 1'b0;
    seq_m = 12'd0;
    send_pkt(3, 1'b1);
    send_pkt(1, 1'b0);
    wait_idle();

    // long run of short packets to pass the sequence wrap (R4)
    for (int p = 0; p < 4100; p++) send_pkt(1, 1'b0);
    wait_idle();

    @(negedge clk);
    #5;
    check(n_v === 1'b0 && w_v === 1'b0, "R1 no extra words", {62'h0, n_v, w_v}, 64'h0);
    summary();
    $finish;
  end
endmodule